// File: doc/BRIEF.md
# Three-Channel Countdown Watchdog Peripheral

This peripheral holds three independent 16-bit countdown watchdogs behind a simple single-cycle read/write register bus. A shared prescaler divides the system clock into a single-cycle tick, nominally ten per second. Each running channel loses one count per tick. Software arms a channel by writing its limit, which also loads the counter. It keeps the channel alive by reading the counter register, and that read reloads the counter from the limit. Reading the limit register, or the status byte, leaves the count untouched.

When a channel runs down to zero, its expired flag is set and it stops counting. Each channel then takes its own action:
- Channel 0 holds an interrupt level.
- Channel 1 emits a one-cycle processor-reset pulse.
- Channel 2 emits a one-cycle whole-system reset pulse.

A shared mask byte suppresses the action of any channel. A masked channel still counts down and still sets its expired flag. Halfword registers travel on the bus with their two bytes exchanged.

Top module: `tri_wdog_ctrl`

## Requirements
- R1: After reset every channel's counter and limit hold 1, so each reads as 0x0100 on the bus. Every status byte and the mask read 0, and all three action outputs are low.
- R2: A write of bus value {B0,B1} (B0 in bits 15:8) to a limit register stores 16-bit value {B1,B0}. The same write loads that value into the counter, sets running and clears expired. Halfword reads return the stored value with its bytes swapped the same way.
- R3: A prescaler asserts a tick once every TICK_DIV clocks, with the first tick TICK_DIV clocks after reset. A running counter decrements by one on each tick. A stopped counter holds its value.
- R4: A read of a counter register returns the count before the read and reloads the counter from the limit. The running flag is not changed.
- R5: A read of a limit register or a status byte leaves the counter unchanged.
- R6: A tick that meets a running counter of 1 or 0 sets the counter to 0, clears running and sets expired. The status byte shows running in bit 0 and expired in bit 1, with all other bits 0. The expired flag stays set until the next limit write to that channel.
- R7: The interrupt output is high exactly while channel 0 is expired and mask bit 0 is 0.
- R8: On the tick that expires channel 1, the processor-reset output goes high for exactly one clock, in the clock after that tick's edge, if mask bit 1 was 0 before that edge. Channel 2 drives the system-reset output by the same rule, using mask bit 2.
- R9: The mask byte sits at offset 0x30. Bits 2:0 map to channels 2:0, and a 1 suppresses that channel's action. A write takes effect from the next clock. A masked channel still counts and still sets its expired flag.
- R10: Channel n's block starts at byte offset 16·n and holds the counter at +0, the limit at +4 and the status byte at +8. Offset 0x34 and all unmapped offsets read 0. Read data appears on rsp_rdata in the clock after the request and holds until the next read.
- R11: A limit write or counter read in the same clock as a tick takes priority over the decrement. The tick has no effect on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 16 | Write data (halfwords byte-swapped) |
| rsp_rdata | output | 16 | Read data, valid the clock after a read |
| irq_out | output | 1 | Channel 0 expiry interrupt level |
| cpu_rst_pulse | output | 1 | Channel 1 processor-reset pulse |
| sys_rst_pulse | output | 1 | Channel 2 system-reset pulse |

## Verification
Every register update happens at the edge that samples the request or the tick. Read data, the interrupt level and the reset pulses therefore all become visible one clock after their cause, and none of them is combinational from the bus. The bench model updates on the same edge as the design and compares all four outputs at the following falling edge. Directed reads sample rsp_rdata at the falling edge after the request's rising edge. Expiry checks wait a bounded number of clocks, a few ticks longer than the programmed limit, before reading status or counting pulses.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;

   // halfword width of every counter/limit register
   localparam int unsigned HW_W = 16;

   // in-block byte offsets of a channel register block
   localparam logic [3:0] OFF_CNT  = 4'h0;
   localparam logic [3:0] OFF_LIM  = 4'h4;
   localparam logic [3:0] OFF_STAT = 4'h8;

   // shared-block absolute offsets
   localparam logic [5:0] ADR_MASK = 6'h30;
   localparam logic [5:0] ADR_DEV  = 6'h34;

   // number of address bits inside one channel block
   localparam int unsigned BLK_BITS = 4;

   typedef enum logic [2:0] {
      RSEL_ZERO,
      RSEL_CNT,
      RSEL_LIM,
      RSEL_STAT,
      RSEL_MASK
   } rsel_e;

   typedef enum logic [1:0] {
      ACT_LEVEL_IRQ,
      ACT_CPU_PULSE,
      ACT_SYS_PULSE
   } act_kind_e;

   function automatic logic [HW_W-1:0] lane_swap(input logic [HW_W-1:0] v);
      return {v[7:0], v[15:8]};
   endfunction

endpackage

// File: rtl/wdt3_prescaler.sv
module wdt3_prescaler #(
   parameter int unsigned TICK_DIV = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

   logic [PW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (div_q == LAST) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign tick_o = (div_q == LAST);

endmodule

// File: rtl/wdt3_busdec.sv
module wdt3_busdec
   import wdt3_pkg::*;
#(
   parameter int unsigned NCH    = 3,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [NCH-1:0]    lim_wr_o,
   output logic [NCH-1:0]    cnt_rd_o,
   output logic              mask_wr_o,
   output rsel_e             rsel_o,
   output logic [1:0]        rch_o
);
   logic [ADDR_W-1:0] hi_part;
   logic              in_window;
   logic [1:0]        blk;
   logic [3:0]        off;
   logic              rd_req;
   logic              wr_req;

   assign hi_part   = req_addr >> 6;
   assign in_window = (hi_part == '0);
   assign blk       = req_addr[5:4];
   assign off       = req_addr[BLK_BITS-1:0];
   assign rd_req    = req_valid && !req_write && in_window;
   assign wr_req    = req_valid &&  req_write && in_window;

   for (genvar i = 0; i < NCH; i++) begin : g_ch_dec
      assign lim_wr_o[i] = wr_req && (blk == 2'(i)) && (off == OFF_LIM);
      assign cnt_rd_o[i] = rd_req && (blk == 2'(i)) && (off == OFF_CNT);
   end

   assign mask_wr_o = wr_req && (req_addr[5:0] == ADR_MASK);

   always_comb begin
      rsel_o = RSEL_ZERO;
      rch_o  = blk;
      if (rd_req) begin
         if (32'(blk) < NCH) begin
            unique case (off)
               OFF_CNT:  rsel_o = RSEL_CNT;
               OFF_LIM:  rsel_o = RSEL_LIM;
               OFF_STAT: rsel_o = RSEL_STAT;
               default:  rsel_o = RSEL_ZERO;
            endcase
         end else if (req_addr[5:0] == ADR_MASK) begin
            rsel_o = RSEL_MASK;
         end else begin
            // device status byte and holes read zero
            rsel_o = RSEL_ZERO;
         end
      end
   end

endmodule

// File: rtl/wdt3_channel.sv
module wdt3_channel
   import wdt3_pkg::*;
#(
   parameter logic [HW_W-1:0] RST_VAL = 16'd1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            load_i,
   input  logic [HW_W-1:0] load_val_i,
   input  logic            svc_i,
   output logic [HW_W-1:0] cnt_o,
   output logic [HW_W-1:0] lim_o,
   output logic            run_o,
   output logic            exp_o,
   output logic            expire_o
);
   logic [HW_W-1:0] cnt_q;
   logic [HW_W-1:0] lim_q;
   logic            run_q;
   logic            exp_q;
   logic            step;
   logic            last;

   // bus operations own the channel in their clock; tick only otherwise
   assign step     = tick_i && run_q && !load_i && !svc_i;
   assign last     = (cnt_q <= HW_W'(1));
   assign expire_o = step && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
         lim_q <= RST_VAL;
         run_q <= 1'b0;
         exp_q <= 1'b0;
      end else if (load_i) begin
         lim_q <= load_val_i;
         cnt_q <= load_val_i;
         run_q <= 1'b1;
         exp_q <= 1'b0;
      end else if (svc_i) begin
         cnt_q <= lim_q;
      end else if (step) begin
         if (last) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign lim_o = lim_q;
   assign run_o = run_q;
   assign exp_o = exp_q;

endmodule

// File: rtl/wdt3_action.sv
module wdt3_action
   import wdt3_pkg::*;
#(
   parameter act_kind_e KIND = ACT_LEVEL_IRQ
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic clear_i,
   input  logic mask_i,
   output logic out_o
);
   logic hold_q;

   if (KIND == ACT_LEVEL_IRQ) begin : g_level
      // sticky request; mask gates only the visible level
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
         end else if (clear_i) begin
            hold_q <= 1'b0;
         end else if (expire_i) begin
            hold_q <= 1'b1;
         end
      end
      assign out_o = hold_q && !mask_i;
   end else begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= 1'b0;
         end else begin
            hold_q <= expire_i && !mask_i && !clear_i;
         end
      end
      assign out_o = hold_q;
   end

endmodule

// File: rtl/tri_wdog_ctrl.sv
module tri_wdog_ctrl
   import wdt3_pkg::*;
#(
   parameter int unsigned     NCH      = 3,
   parameter int unsigned     ADDR_W   = 6,
   parameter int unsigned     TICK_DIV = 5_000_000,
   parameter logic [HW_W-1:0] RST_VAL  = 16'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [HW_W-1:0]   req_wdata,
   output logic [HW_W-1:0]   rsp_rdata,
   output logic              irq_out,
   output logic              cpu_rst_pulse,
   output logic              sys_rst_pulse
);
   // elaboration-time parameter checks
   if (NCH < 1 || NCH > 3) begin : g_chk_nch
      $error("tri_wdog_ctrl: NCH must be 1..3");
   end
   if (ADDR_W < 6) begin : g_chk_aw
      $error("tri_wdog_ctrl: ADDR_W must cover offset 0x34");
   end
   if (TICK_DIV < 2) begin : g_chk_div
      $error("tri_wdog_ctrl: TICK_DIV must be at least 2");
   end

   logic              tick;
   logic [NCH-1:0]    lim_wr;
   logic [NCH-1:0]    cnt_rd;
   logic              mask_wr;
   rsel_e             rsel;
   logic [1:0]        rch;
   logic [NCH-1:0]    mask_q;
   logic [HW_W-1:0]   cnt_all [NCH];
   logic [HW_W-1:0]   lim_all [NCH];
   logic [NCH-1:0]    run_all;
   logic [NCH-1:0]    exp_all;
   logic [NCH-1:0]    expire_all;
   logic [NCH-1:0]    act_all;
   logic [HW_W-1:0]   wr_val;
   logic [HW_W-1:0]   rd_mux;
   logic [HW_W-1:0]   rdata_q;

   wdt3_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   wdt3_busdec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .lim_wr_o  (lim_wr),
      .cnt_rd_o  (cnt_rd),
      .mask_wr_o (mask_wr),
      .rsel_o    (rsel),
      .rch_o     (rch)
   );

   assign wr_val = lane_swap(req_wdata);

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      localparam act_kind_e KIND = act_kind_e'(i);

      wdt3_channel #(.RST_VAL(RST_VAL)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick_i     (tick),
         .load_i     (lim_wr[i]),
         .load_val_i (wr_val),
         .svc_i      (cnt_rd[i]),
         .cnt_o      (cnt_all[i]),
         .lim_o      (lim_all[i]),
         .run_o      (run_all[i]),
         .exp_o      (exp_all[i]),
         .expire_o   (expire_all[i])
      );

      wdt3_action #(.KIND(KIND)) u_act (
         .clk      (clk),
         .rst_n    (rst_n),
         .expire_i (expire_all[i]),
         .clear_i  (lim_wr[i]),
         .mask_i   (mask_q[i]),
         .out_o    (act_all[i])
      );
   end

   // shared mask byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_wr) begin
         mask_q <= req_wdata[NCH-1:0];
      end
   end

   // read multiplexer; decoder guarantees rch < NCH for channel selects
   always_comb begin
      rd_mux = '0;
      unique case (rsel)
         RSEL_CNT:  rd_mux = lane_swap(cnt_all[rch]);
         RSEL_LIM:  rd_mux = lane_swap(lim_all[rch]);
         RSEL_STAT: rd_mux = {14'd0, exp_all[rch], run_all[rch]};
         RSEL_MASK: rd_mux = HW_W'(mask_q);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (req_valid && !req_write) begin
         rdata_q <= rd_mux;
      end
   end

   assign rsp_rdata = rdata_q;
   assign irq_out   = act_all[0];

   if (NCH > 1) begin : g_cpu_out
      assign cpu_rst_pulse = act_all[1];
   end else begin : g_cpu_none
      assign cpu_rst_pulse = 1'b0;
   end

   if (NCH > 2) begin : g_sys_out
      assign sys_rst_pulse = act_all[2];
   end else begin : g_sys_none
      assign sys_rst_pulse = 1'b0;
   end

endmodule

// File: rtl/tri_wdog_ctrl_chk.sv
module tri_wdog_ctrl_chk #(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [15:0]       req_wdata,
   input logic              irq_out,
   input logic              cpu_rst_pulse,
   input logic [15:0]       cnt0,
   input logic [15:0]       lim0,
   input logic              run0,
   input logic              exp0,
   input logic              exp1
);
   logic rd_cnt0, rd_lim0, wr_lim0, wr_mask_b0;

   assign rd_cnt0    = req_valid && !req_write && (req_addr == ADDR_W'(0));
   assign rd_lim0    = req_valid && !req_write && (req_addr == ADDR_W'(4));
   assign wr_lim0    = req_valid &&  req_write && (req_addr == ADDR_W'(4));
   assign wr_mask_b0 = req_valid &&  req_write && (req_addr == ADDR_W'(48)) && req_wdata[0];

   p_limit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lim0 |=> (cnt0 == {$past(req_wdata[7:0]), $past(req_wdata[15:8])}) && run0 && !exp0);

   p_service_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt0 |=> (cnt0 == lim0));

   p_limit_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lim0 && !run0) |=> $stable(cnt0));

   p_expiry_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp0) |-> ((cnt0 == 16'd0) && !run0));

   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask_b0 |=> !irq_out);

   p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_pulse |=> !cpu_rst_pulse);

   p_pulse_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_pulse |-> exp1);

endmodule

bind tri_wdog_ctrl tri_wdog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_write     (req_write),
   .req_addr      (req_addr),
   .req_wdata     (req_wdata),
   .irq_out       (irq_out),
   .cpu_rst_pulse (cpu_rst_pulse),
   .cnt0          (cnt_all[0]),
   .lim0          (lim_all[0]),
   .run0          (run_all[0]),
   .exp0          (exp_all[0]),
   .exp1          (exp_all[1])
);

// File: tb/tri_wdog_ctrl_tb_top.sv
module tri_wdog_ctrl_tb_top;
   localparam int DIV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic        irq_out, cpu_rst_pulse, sys_rst_pulse;

   int checks = 0;
   int errors = 0;
   int cpu_seen = 0;
   int sys_seen = 0;
   bit run_cmp = 1'b0;

   always #10 clk = ~clk;

   tri_wdog_ctrl #(.TICK_DIV(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .irq_out(irq_out), .cpu_rst_pulse(cpu_rst_pulse), .sys_rst_pulse(sys_rst_pulse)
   );

   // ---------------- behavioural reference model ----------------
   int          m_cnt [3];
   int          m_lim [3];
   bit          m_run [3];
   bit          m_exp [3];
   int          m_mask, m_pc;
   logic [15:0] m_rdata;
   bit          m_cpu, m_sys, nx_cpu, nx_sys, tk;
   int          a_blk, a_off;

   function automatic logic [15:0] sw(input int v);
      logic [15:0] t = 16'(v);
      return {t[7:0], t[15:8]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 1; m_lim[c] = 1; m_run[c] = 0; m_exp[c] = 0;
         end
         m_mask = 0; m_pc = 0; m_rdata = '0; m_cpu = 0; m_sys = 0;
      end else begin
         tk = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         a_blk = int'(req_addr) / 16;
         a_off = int'(req_addr) % 16;
         nx_cpu = 0; nx_sys = 0;
         if (req_valid && !req_write) begin
            if (a_blk < 3 && a_off == 0)      m_rdata = sw(m_cnt[a_blk]);
            else if (a_blk < 3 && a_off == 4) m_rdata = sw(m_lim[a_blk]);
            else if (a_blk < 3 && a_off == 8) m_rdata = {14'd0, m_exp[a_blk], m_run[a_blk]};
            else if (req_addr == 6'h30)       m_rdata = 16'(m_mask);
            else                              m_rdata = '0;
         end
         for (int c = 0; c < 3; c++) begin
            if (req_valid && req_write && a_blk == c && a_off == 4) begin
               m_lim[c] = int'({req_wdata[7:0], req_wdata[15:8]});
               m_cnt[c] = m_lim[c]; m_run[c] = 1; m_exp[c] = 0;
            end else if (req_valid && !req_write && a_blk == c && a_off == 0) begin
               m_cnt[c] = m_lim[c];
            end else if (tk && m_run[c]) begin
               if (m_cnt[c] <= 1) begin
                  m_cnt[c] = 0; m_run[c] = 0; m_exp[c] = 1;
                  if (c == 1 && !m_mask[1]) nx_cpu = 1;
                  if (c == 2 && !m_mask[2]) nx_sys = 1;
               end else begin
                  m_cnt[c] = m_cnt[c] - 1;
               end
            end
         end
         if (req_valid && req_write && req_addr == 6'h30) m_mask = int'(req_wdata[2:0]);
         m_cpu = nx_cpu; m_sys = nx_sys;
      end
   end

   task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", rq, act, expv, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (run_cmp) begin
         chk("R10 rdata", rsp_rdata, m_rdata);
         chk("R7 irq", 16'(irq_out), 16'(m_exp[0] && !m_mask[0]));
         chk("R8 cpu pulse", 16'(cpu_rst_pulse), 16'(m_cpu));
         chk("R8 sys pulse", 16'(sys_rst_pulse), 16'(m_sys));
         if (cpu_rst_pulse) cpu_seen++;
         if (sys_rst_pulse) sys_seen++;
      end
   end

   task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      d = rsp_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      int c0, s0;
      idle(3);
      // R1: reset state
      chk("R1 irq", 16'(irq_out), 16'd0);
      chk("R1 cpu", 16'(cpu_rst_pulse), 16'd0);
      chk("R1 sys", 16'(sys_rst_pulse), 16'd0);
      rst_n = 1;
      run_cmp = 1;
      bus_rd(6'h00, d); chk("R1 ch0 counter", d, 16'h0100);
      bus_rd(6'h24, d); chk("R1 ch2 limit", d, 16'h0100);
      bus_rd(6'h18, d); chk("R1 ch1 status", d, 16'h0000);
      bus_rd(6'h30, d); chk("R1 mask", d, 16'h0000);

      // R2: byte-swapped limit load, running set
      bus_wr(6'h04, 16'h0500);
      bus_rd(6'h04, d); chk("R2 ch0 limit", d, 16'h0500);
      bus_rd(6'h08, d); chk("R2 ch0 running", d, 16'h0001);
      bus_rd(6'h14, d); chk("R5 ch1 limit read", d, 16'h0100);
      bus_rd(6'h10, d); chk("R5 ch1 counter after limit read", d, 16'h0100);

      // R3/R6/R7: ch0 expires, interrupt rises
      for (int i = 0; i < 100 && !irq_out; i++) idle(1);
      chk("R7 irq raised", 16'(irq_out), 16'd1);
      bus_rd(6'h08, d); chk("R6 ch0 expired", d, 16'h0002);
      bus_rd(6'h00, d); chk("R6 ch0 counter zero", d, 16'h0000);
      // R9: masking drops the level
      bus_wr(6'h30, 16'h0001);
      chk("R9 irq masked", 16'(irq_out), 16'd0);
      bus_rd(6'h30, d); chk("R9 mask readback", d, 16'h0001);

      // R8: ch1 single pulse
      c0 = cpu_seen;
      bus_wr(6'h14, 16'h0300);
      idle(60);
      chk("R8 one cpu pulse", 16'(cpu_seen - c0), 16'd1);

      // R9: masked ch2 still expires without pulse
      bus_wr(6'h30, 16'h0004);
      s0 = sys_seen;
      bus_wr(6'h24, 16'h0200);
      idle(50);
      chk("R9 no sys pulse", 16'(sys_seen - s0), 16'd0);
      bus_rd(6'h28, d); chk("R9 ch2 expired", d, 16'h0002);
      bus_wr(6'h30, 16'h0000);
      s0 = sys_seen;
      bus_wr(6'h24, 16'h0100);
      idle(30);
      chk("R8 sys pulse", 16'(sys_seen - s0), 16'd1);

      // R4: servicing keeps ch1 alive
      c0 = cpu_seen;
      bus_wr(6'h14, 16'h0400);
      for (int k = 0; k < 12; k++) begin
         idle(10);
         bus_rd(6'h10, d);
      end
      chk("R4 no cpu pulse while serviced", 16'(cpu_seen - c0), 16'd0);
      bus_rd(6'h18, d); chk("R4 ch1 still running", d, 16'h0001);

      // R10: holes and device status byte
      bus_rd(6'h34, d); chk("R10 device status", d, 16'h0000);
      bus_rd(6'h0C, d); chk("R10 hole", d, 16'h0000);
      bus_rd(6'h3C, d); chk("R10 top hole", d, 16'h0000);

      // R11: bus operations at every prescaler phase (model compares each clock)
      for (int ph = 0; ph < DIV; ph++) begin
         bus_wr(6'h04, 16'h0300);
         idle(ph);
         bus_rd(6'h00, d);
         idle(3);
      end
      idle(60);
      bus_rd(6'h08, d); chk("R11 ch0 expired after phase sweep", d, 16'h0002);
      finish_run();
   end

endmodule